// File: doc/BRIEF.md
# Multi-Channel Logic Trigger Matcher

This block watches a vector of sampled logic inputs and emits a single trigger pulse once every armed channel meets its configured condition in the same sample. Each channel can be left out of the trigger, asked for a static high or low level, or asked for a rising or falling transition. Four configuration masks are loaded through a small write port. A sample is taken on each cycle with the sample strobe high.

Software arms the block with a one-cycle `arm` pulse. The block then checks each strobed sample against the masks. When all active conditions hold, it raises `trig_pulse` for one clock and disarms itself. At most one channel may be edge-qualified. A configuration with more than one edge channel raises `cfg_err`, and while that flag is set no trigger is produced.

Top module: `trig_matcher`

## Requirements
- R1: After reset, `trig_pulse` and `cfg_err` are low and the block is disarmed, so strobed samples produce no pulse. The capture mask resets to all ones and the other three masks reset to all zeros.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the mask chosen by `cfg_sel` and takes effect from the next cycle. The selectors are 0 = capture enable, 1 = trigger enable, 2 = level select, 3 = polarity.
- R3: A channel with its trigger bit and level bit both set is satisfied when its input equals its polarity bit: polarity 1 requires high and polarity 0 requires low.
- R4: A channel with its trigger bit set and its level bit clear is an edge condition: polarity 0 requires a rising edge and polarity 1 a falling edge. The edge is judged against the previous sample taken on a strobe while armed. The first strobed sample after arming cannot satisfy an edge condition.
- R5: A channel whose capture bit is clear takes no part in the trigger or in the edge-count check, whatever its other mask bits are.
- R6: All active conditions are combined by AND within one sample; a single failing channel blocks the trigger.
- R7: `cfg_err` is high exactly when two or more channels are edge conditions after R5 masking. While it is high no pulse is produced and the block stays armed.
- R8: With no active trigger channel, the first strobed sample after arming produces the pulse.
- R9: `trig_pulse` goes high for exactly one clock, in the cycle after the qualifying strobe. The block is then disarmed and later matches give no pulse until the next `arm`.
- R10: When `arm` and `smp_en` are high in the same cycle, arming wins and that sample is not evaluated or stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Mask selector for the write |
| cfg_wdata | input | NCH | Mask value to write |
| arm | input | 1 | Arm pulse; clears sample history |
| smp_en | input | 1 | Sample strobe |
| smp_data | input | NCH | Sampled channel inputs |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| cfg_err | output | 1 | More than one edge channel configured |

## Verification
A stale previous-sample register shows up at the first or second strobe after arming, as a spurious or missing edge pulse. A wrong polarity or level decode on any channel changes the pulse on the very next strobe. The bench sweeps every channel through all four condition kinds, so a fault in any lane shows within a few samples. Disarm and error-suppression faults show as an extra pulse one cycle after a matching strobe that should have been ignored.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

    localparam int unsigned CFG_SEL_W = 2;

    typedef enum logic [CFG_SEL_W-1:0] {
        SEL_CAPTURE  = 2'd0,
        SEL_TRIG_EN  = 2'd1,
        SEL_LEVEL    = 2'd2,
        SEL_POLARITY = 2'd3
    } cfg_sel_e;

    // Edge test for one lane: polarity 0 = rising, 1 = falling.
    function automatic logic edge_match(input logic prev, input logic cur, input logic pol);
        return pol ? (prev & ~cur) : (~prev & cur);
    endfunction

    // Level test for one lane: input must equal polarity.
    function automatic logic level_match(input logic cur, input logic pol);
        return cur == pol;
    endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_match_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_SEL_W-1:0] sel,
    input  logic [NCH-1:0]       wdata,
    output logic [NCH-1:0]       eff_en,
    output logic [NCH-1:0]       lvl,
    output logic [NCH-1:0]       pol,
    output logic                 err
);
    localparam int unsigned CNT_W = $clog2(NCH + 1);

    logic [NCH-1:0] cap_q, ten_q, lvl_q, pol_q;
    logic [NCH-1:0] edge_bits;
    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '1;
            ten_q <= '0;
            lvl_q <= '0;
            pol_q <= '0;
        end else if (we) begin
            unique case (cfg_sel_e'(sel))
                SEL_CAPTURE:  cap_q <= wdata;
                SEL_TRIG_EN:  ten_q <= wdata;
                SEL_LEVEL:    lvl_q <= wdata;
                SEL_POLARITY: pol_q <= wdata;
                default:      ;
            endcase
        end
    end

    assign eff_en    = ten_q & cap_q;
    assign edge_bits = eff_en & ~lvl_q;

    always_comb begin
        edge_cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            edge_cnt = edge_cnt + CNT_W'(edge_bits[i]);
        end
    end

    assign err = edge_cnt > CNT_W'(1);
    assign lvl = lvl_q;
    assign pol = pol_q;

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_TRIG_EN) |=> (ten_q == $past(wdata)));

    assert_pol_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_POLARITY) |=> (pol == $past(wdata)));

endmodule

// File: rtl/trig_chan_match.sv
module trig_chan_match
    import trig_match_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] lvl,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] cur,
    input  logic [NCH-1:0] prev,
    input  logic           prev_valid,
    output logic           all_match
);
    logic [NCH-1:0] ch_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic lvl_hit, edge_hit;
        assign lvl_hit  = level_match(cur[i], pol[i]);
        assign edge_hit = prev_valid & edge_match(prev[i], cur[i], pol[i]);
        assign ch_ok[i] = ~en[i] | (lvl[i] ? lvl_hit : edge_hit);
    end

    assign all_match = &ch_ok;

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm,
    input  logic           smp_en,
    input  logic [NCH-1:0] smp_data,
    input  logic           all_match,
    input  logic           cfg_err,
    output logic [NCH-1:0] prev_smp,
    output logic           prev_valid,
    output logic           trig
);
    logic armed;
    logic fire;

    assign fire = !arm && armed && smp_en && all_match && !cfg_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            prev_valid <= 1'b0;
            prev_smp   <= '0;
            trig       <= 1'b0;
        end else begin
            trig <= fire;
            if (arm) begin
                armed      <= 1'b1;
                prev_valid <= 1'b0;
            end else if (armed && smp_en) begin
                prev_smp   <= smp_data;
                prev_valid <= 1'b1;
                if (fire) armed <= 1'b0;
            end
        end
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    assert_err_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(!cfg_err));

    assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(armed && smp_en && !arm));

    assert_arm_wins_R10: assert property (@(posedge clk) disable iff (rst)
        arm |=> !trig);

endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
    import trig_match_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [NCH-1:0]       cfg_wdata,
    input  logic                 arm,
    input  logic                 smp_en,
    input  logic [NCH-1:0]       smp_data,
    output logic                 trig_pulse,
    output logic                 cfg_err
);
    logic [NCH-1:0] eff_en, lvl, pol, prev_smp;
    logic prev_valid, all_match;

    trig_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .eff_en(eff_en), .lvl(lvl), .pol(pol), .err(cfg_err)
    );

    trig_chan_match #(.NCH(NCH)) u_match (
        .en(eff_en), .lvl(lvl), .pol(pol), .cur(smp_data),
        .prev(prev_smp), .prev_valid(prev_valid), .all_match(all_match)
    );

    trig_ctrl #(.NCH(NCH)) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .smp_en(smp_en), .smp_data(smp_data),
        .all_match(all_match), .cfg_err(cfg_err), .prev_smp(prev_smp),
        .prev_valid(prev_valid), .trig(trig_pulse)
    );

    assert_no_pulse_in_reset_R1: assert property (@(posedge clk)
        rst |=> !trig_pulse);

endmodule

// File: tb/trig_matcher_test.sv
module trig_matcher_test;
    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [NCH-1:0] cfg_wdata = '0;
    logic arm = 1'b0;
    logic smp_en = 1'b0;
    logic [NCH-1:0] smp_data = '0;
    logic trig_pulse, cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic [NCH-1:0] m_cap, m_ten, m_lvl, m_pol, m_prev;
    bit m_armed, m_pv;
    logic [31:0] rng = 32'h1234_5678;

    trig_matcher #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .arm(arm), .smp_en(smp_en),
        .smp_data(smp_data), .trig_pulse(trig_pulse), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic bit model_err();
        int n = 0;
        for (int i = 0; i < NCH; i++)
            if (m_cap[i] && m_ten[i] && !m_lvl[i]) n++;
        return n > 1;
    endfunction

    function automatic bit model_match(input logic [NCH-1:0] d);
        bit ok = 1;
        for (int i = 0; i < NCH; i++) begin
            if (m_cap[i] && m_ten[i]) begin
                if (m_lvl[i]) begin
                    if (d[i] != m_pol[i]) ok = 0;
                end else begin
                    if (!m_pv) ok = 0;
                    else if (m_pol[i] == 1'b0 && !(m_prev[i] == 1'b0 && d[i] == 1'b1)) ok = 0;
                    else if (m_pol[i] == 1'b1 && !(m_prev[i] == 1'b1 && d[i] == 1'b0)) ok = 0;
                end
            end
        end
        return ok;
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int sel, input logic [NCH-1:0] val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_cap = val;
            1: m_ten = val;
            2: m_lvl = val;
            default: m_pol = val;
        endcase
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        m_armed = 1; m_pv = 0;
        check(trig_pulse == 1'b0, "R10", trig_pulse, 0);
    endtask

    task automatic step(input logic [NCH-1:0] d, input string req);
        bit exp;
        exp = m_armed && !model_err() && model_match(d);
        smp_data = d; smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
        if (m_armed) begin m_prev = d; m_pv = 1; end
        if (exp) m_armed = 0;
        check(trig_pulse == exp, req, trig_pulse, exp);
        @(negedge clk);
        check(trig_pulse == 1'b0, "R9", trig_pulse, 0);
    endtask

    task automatic load(input logic [NCH-1:0] cap, ten, lvl, pol);
        write_cfg(0, cap); write_cfg(1, ten); write_cfg(2, lvl); write_cfg(3, pol);
        check(cfg_err == model_err(), "R7", cfg_err, model_err());
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_cap = '1; m_ten = '0; m_lvl = '0; m_pol = '0; m_prev = '0;
        m_armed = 0; m_pv = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, unarmed strobes give nothing
        check(trig_pulse == 0 && cfg_err == 0, "R1", {trig_pulse, cfg_err}, 0);
        step('1, "R1");
        step('0, "R1");

        // R8: empty trigger mask fires on first strobe after arming
        do_arm();
        step(16'h5a5a, "R8");
        step(16'h5a5a, "R9");   // disarmed: no second pulse

        // R3/R4 sweep every channel through all four condition kinds
        for (int c = 0; c < NCH; c++) begin
            for (int mode = 0; mode < 4; mode++) begin
                logic [NCH-1:0] bitm;
                bitm = NCH'(1) << c;
                load('1, bitm, (mode < 2) ? bitm : '0,
                     (mode == 0 || mode == 3) ? bitm : '0);
                do_arm();
                for (int k = 0; k < 6; k++) begin
                    logic [NCH-1:0] d;
                    rng = next_rng(rng);
                    d = rng[NCH-1:0] & ~bitm;
                    if (((k >> 1) & 1) != 0) d = d | bitm;
                    if (mode == 3 && k == 0) d = d | bitm;
                    step(d, (mode < 2) ? "R3" : "R4");
                end
            end
        end

        // R4: first sample after arming cannot produce an edge
        load('1, 16'h0001, '0, '0);
        do_arm();
        step(16'h0001, "R4");
        step(16'h0001, "R4");
        step(16'h0000, "R4");
        step(16'h0001, "R4");

        // R5: capture-disabled channel is ignored, also in edge count
        load(16'hfffe, 16'h0003, 16'h0002, 16'h0002);
        do_arm();
        step(16'h0002, "R5");
        load(16'hfffe, 16'h0003, 16'h0000, 16'h0000);
        check(cfg_err == 0, "R5", cfg_err, 0);

        // R7: two edge channels flag error and block trigger
        load('1, 16'h0003, 16'h0000, 16'h0000);
        check(cfg_err == 1, "R7", cfg_err, 1);
        do_arm();
        step(16'h0000, "R7");
        step(16'h0003, "R7");
        load('1, 16'h0003, 16'h0001, 16'h0001);
        check(cfg_err == 0, "R7", cfg_err, 0);
        step(16'h0001, "R7");   // still armed, prev=3, level ok, ch1 no edge
        step(16'h0003, "R7");   // ch1 rising, ch0 high -> fire

        // R6: mixed level/edge ANDed, random multi-channel configs
        for (int t = 0; t < 300; t++) begin
            logic [NCH-1:0] ten, lvl, pol, e;
            rng = next_rng(rng); ten = rng[15:0] & rng[31:16];
            rng = next_rng(rng); pol = rng[15:0];
            lvl = ten;
            e = NCH'(1) << (t % NCH);
            if (t % 3 == 0) begin ten = ten | e; lvl = lvl & ~e; end
            load('1, ten, lvl, pol);
            do_arm();
            for (int k = 0; k < 5; k++) begin
                logic [NCH-1:0] d;
                rng = next_rng(rng);
                d = (k % 2 == 1) ? ((pol & lvl) | (rng[15:0] & ~lvl)) : rng[15:0];
                step(d, "R6");
            end
        end

        // R10: arm together with a matching strobe is not evaluated
        load('1, 16'h0000, '0, '0);
        arm = 1'b1; smp_en = 1'b1; smp_data = 16'h0000;
        @(negedge clk);
        arm = 1'b0; smp_en = 1'b0;
        m_armed = 1; m_pv = 0;
        check(trig_pulse == 0, "R10", trig_pulse, 0);
        step(16'h0000, "R10");

        // R2: rewrite of a single mask changes behaviour next cycle
        load('1, 16'h8000, 16'h8000, 16'h8000);
        do_arm();
        step(16'h0000, "R2");
        write_cfg(3, 16'h0000);
        step(16'h0000, "R2");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule